// File: doc/BRIEF.md
# Prioritizing Interrupt Controller with End-of-Service

This block collects up to `N_SRC` interrupt request lines and drives one interrupt line toward a processor. The `EDGE_SEL` parameter makes each input either level-sensed or rising-edge-sensed. Pending requests are kept in an internal request vector that software cannot reach. A small write/read port gives software a mask register, a priority-mode bit and an end-of-service command. The same port reads back the mask, the mode and the in-service vector.

The processor accepts an interrupt by pulsing `ack`. In that same cycle `ack_vec` carries the index of the winning source. On the following clock edge that source moves from pending to in service. It stays in service until software issues an end-of-service command. That command retires the highest-priority in-service source.

In fixed mode, index 0 outranks every other index. In rotating mode, the source retired by the last end-of-service command drops to lowest priority and the index after it becomes highest. A pending source can interrupt the processor only when it outranks every source currently in service, so higher-priority work can nest over lower-priority work.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the in-service vector is zero, every mask bit reads 1, the mode bit reads 0 (fixed), and `irq_out` is low.
- R2: A source whose mask bit is 1 never raises `irq_out` and is never returned on `ack`. Writing address 0 loads the mask, and the written value reads back.
- R3: In fixed mode the lowest-numbered eligible pending source wins.
- R4: In rotating mode, an end-of-service that retires source s moves the priority base to (s+1) mod N_SRC. Index base+k then has rank k, and rank 0 is highest.
- R5: When `ack` is high and `irq_out` is high, `ack_vec` gives the winner's index in the same cycle. The winner's in-service bit is set on the next edge.
- R6: When `ack` is high and `irq_out` is low, `ack_vec` reads N_SRC-1 and no state changes.
- R7: `irq_out` is high exactly when some unmasked pending source has a better rank than the best in-service source, or when such a source is pending and nothing is in service.
- R8: A write to address 2 is an end-of-service command. It clears the in-service bit of best rank. If nothing is in service it has no effect.
- R9: An edge-sensed input (EDGE_SEL bit = 1) becomes pending only on a low-to-high change. A line held high after its service ends raises no new request.
- R10: A level-sensed input is pending while the line was high at the previous clock edge, and stops being pending when the line goes low.
- R11: Register reads are combinational on `reg_rdata`: address 0 returns the mask, address 1 returns the mode in bit 0 (1 = rotating), address 2 returns the in-service vector, and address 3 returns zero. A write to address 1 loads the mode from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_SRC | Request lines |
| ack | input | 1 | Processor acknowledge strobe |
| ack_vec | output | log2(N_SRC) | Granted index (N_SRC-1 when nothing is eligible) |
| irq_out | output | 1 | Interrupt to processor |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data |

## Verification
The assertions check on every cycle that a masked source is never granted, that `irq_out` always has an unmasked pending source behind it, and that a grant lands in the in-service vector. They also check that an idle acknowledge returns N_SRC-1 without touching state, that one end-of-service retires exactly one source, and that in fixed mode no lower-numbered eligible source is passed over. Only the bench scenarios can show the rotating order after a chain of retirements, nesting of a better source over one in service, and that a held edge line stays silent after its service ends. The bench scenarios also show that a level line drops its request when it falls.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Register address codes on the software port
  typedef enum logic [1:0] {
    RA_MASK  = 2'd0,
    RA_MODE  = 2'd1,
    RA_SVC   = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Finds the set bit of best rank; rank k sits at index (base + k) mod N_SRC.
module irq_prio_pick #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vec,
  input  logic [IW-1:0]    base,
  output logic             found,
  output logic [IW-1:0]    idx,
  output logic [IW-1:0]    rank
);
  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] b, input int k);
    return b + IW'(k);
  endfunction

  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (!found && vec[wrap_add(base, k)]) begin
        found = 1'b1;
        idx   = wrap_add(base, k);
        rank  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_prio_capture.sv
// Per-input request capture: edge or level sensing chosen by EDGE_SEL (R9, R10).
module irq_prio_capture #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] EDGE_SEL = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] grant_clr,
  output logic [N_SRC-1:0] req
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_SEL[i]) begin : g_edge
      logic prev_q;
      logic rise;
      assign rise = irq_in[i] & ~prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          req[i] <= 1'b0;
        end else begin
          prev_q <= irq_in[i];
          req[i] <= (req[i] & ~grant_clr[i]) | rise;
        end
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req[i] <= 1'b0;
        else        req[i] <= irq_in[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_service.sv
// In-service vector and rotation base (R4, R5, R8).
module irq_prio_service #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_en,
  input  logic [IW-1:0]    grant_idx,
  input  logic             eoi_en,
  input  logic             rot_en,
  output logic [N_SRC-1:0] isr,
  output logic [IW-1:0]    base_eff,
  output logic             svc_found,
  output logic [IW-1:0]    svc_idx,
  output logic [IW-1:0]    svc_rank
);
  logic [IW-1:0]    base_q;
  logic             retire;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] clr_vec;

  assign base_eff = rot_en ? base_q : '0;

  irq_prio_pick #(.N_SRC(N_SRC)) svc_pick_i (
    .vec(isr), .base(base_eff),
    .found(svc_found), .idx(svc_idx), .rank(svc_rank)
  );

  assign retire  = eoi_en && svc_found;
  assign set_vec = grant_en ? (N_SRC'(1) << grant_idx) : '0;
  assign clr_vec = retire   ? (N_SRC'(1) << svc_idx)   : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr    <= '0;
      base_q <= '0;
    end else begin
      isr <= (isr & ~clr_vec) | set_vec;
      if (retire && rot_en) base_q <= svc_idx + IW'(1);
    end
  end
endmodule

// File: rtl/irq_prio_regs.sv
// Software port: mask, mode, end-of-service command, read mux (R1, R2, R11).
module irq_prio_regs #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [N_SRC-1:0] wdata,
  input  logic [N_SRC-1:0] isr,
  output logic [N_SRC-1:0] mask,
  output logic             rot_en,
  output logic             eoi_cmd,
  output logic [N_SRC-1:0] rdata
);
  import irq_prio_pkg::*;
  reg_addr_e sel;
  assign sel     = reg_addr_e'(addr);
  assign eoi_cmd = we && (sel == RA_SVC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '1;
      rot_en <= 1'b0;
    end else if (we) begin
      if (sel == RA_MASK) mask   <= wdata;
      if (sel == RA_MODE) rot_en <= wdata[0];
    end
  end

  always_comb begin
    case (sel)
      RA_MASK: rdata = mask;
      RA_MODE: rdata = {{(N_SRC-1){1'b0}}, rot_en};
      RA_SVC:  rdata = isr;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] EDGE_SEL = 8'hF0,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             ack,
  output logic [IW-1:0]    ack_vec,
  output logic             irq_out,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata
);
  logic [N_SRC-1:0] req_vec, mask_vec, isr_vec, cand_vec, grant_clr;
  logic             rot_mode, eoi_cmd, grant;
  logic             cand_found, svc_found;
  logic [IW-1:0]    cand_idx, cand_rank, svc_idx, svc_rank, base_eff;

  irq_prio_regs #(.N_SRC(N_SRC)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .isr(isr_vec), .mask(mask_vec), .rot_en(rot_mode), .eoi_cmd(eoi_cmd),
    .rdata(reg_rdata)
  );

  irq_prio_capture #(.N_SRC(N_SRC), .EDGE_SEL(EDGE_SEL)) cap_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .grant_clr(grant_clr), .req(req_vec)
  );

  // Eligible pending sources: masked ones are invisible (R2)
  assign cand_vec = req_vec & ~mask_vec;

  irq_prio_pick #(.N_SRC(N_SRC)) cand_pick_i (
    .vec(cand_vec), .base(base_eff),
    .found(cand_found), .idx(cand_idx), .rank(cand_rank)
  );

  irq_prio_service #(.N_SRC(N_SRC)) svc_i (
    .clk(clk), .rst_n(rst_n), .grant_en(grant), .grant_idx(cand_idx),
    .eoi_en(eoi_cmd), .rot_en(rot_mode), .isr(isr_vec), .base_eff(base_eff),
    .svc_found(svc_found), .svc_idx(svc_idx), .svc_rank(svc_rank)
  );

  // R7: raise only when the best candidate outranks the best in-service source
  assign irq_out   = cand_found && (!svc_found || (cand_rank < svc_rank));
  assign grant     = ack && irq_out;
  assign grant_clr = grant ? (N_SRC'(1) << cand_idx) : '0;
  assign ack_vec   = irq_out ? cand_idx : IW'(N_SRC - 1);   // R5, R6
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic [IW-1:0]    ack_vec,
  input logic             irq_out,
  input logic [N_SRC-1:0] req,
  input logic [N_SRC-1:0] mask,
  input logic [N_SRC-1:0] isr,
  input logic             rot,
  input logic             eoi
);
  logic [N_SRC-1:0] below_bits;
  assign below_bits = (N_SRC'(1) << ack_vec) - N_SRC'(1);

  AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |-> !mask[ack_vec]); // R2
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(req & ~mask))); // R7
  AST_FIXED_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !rot) |-> ((req & ~mask & below_bits) == '0)); // R3
  AST_GRANT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> isr[$past(ack_vec)]); // R5
  AST_IDLE_ACK_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out) |-> (ack_vec == IW'(N_SRC - 1))); // R6
  AST_IDLE_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out && !eoi) |=> $stable(isr)); // R6
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(ack && irq_out) && (|isr)) |=> ($countones(isr) + 1 == $past($countones(isr)))); // R8
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .ack_vec(ack_vec), .irq_out(irq_out),
  .req(req_vec), .mask(mask_vec), .isr(isr_vec), .rot(rot_mode), .eoi(eoi_cmd)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam logic [7:0] EDGES = 8'hF0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       ack = 1'b0;
  logic [2:0] ack_vec;
  logic       irq_out;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [7:0] m_req, m_prev, m_isr, m_mask;
  bit         m_rot;
  int         m_base;
  int         last_vec, last_irq, last_rd;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .ack_vec(ack_vec),
    .irq_out(irq_out), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Best rank = smallest distance above the base
  function automatic void mpick(input logic [7:0] v, input int b,
                                output bit f, output int idx, output int rk);
    f = 0; idx = 0; rk = 99;
    for (int i = 0; i < 8; i++) begin
      if (v[i] && ((i + 8 - b) % 8) < rk) begin
        rk = (i + 8 - b) % 8; idx = i; f = 1;
      end
    end
  endfunction

  task automatic step(input logic [7:0] in_v, input bit a, input bit we,
                      input logic [1:0] ad, input logic [7:0] wd, input string tag);
    bit cf, sf, e_irq, grant, eoi;
    int ci, cr, si, sr, be, e_vec, e_rd;
    logic [7:0] nreq;
    @(negedge clk);
    irq_in = in_v; ack = a; reg_we = we; reg_addr = ad; reg_wdata = wd;
    #2;
    be = m_rot ? m_base : 0;
    mpick(m_req & ~m_mask, be, cf, ci, cr);
    mpick(m_isr, be, sf, si, sr);
    e_irq = cf && (!sf || cr < sr);
    e_vec = e_irq ? ci : 7;
    case (ad)
      2'd0: e_rd = m_mask;
      2'd1: e_rd = {7'b0, m_rot};
      2'd2: e_rd = m_isr;
      default: e_rd = 0;
    endcase
    last_irq = irq_out; last_vec = ack_vec; last_rd = reg_rdata;
    check({tag, "/R7 irq_out"}, irq_out, e_irq);
    if (a) check({tag, "/R5 ack_vec"}, ack_vec, e_vec);
    check({tag, "/R11 rdata"}, reg_rdata, e_rd);
    // next state of the reference
    grant = a && e_irq;
    eoi = we && ad == 2'd2;
    for (int i = 0; i < 8; i++)
      nreq[i] = EDGES[i] ? ((m_req[i] && !(grant && ci == i)) || (in_v[i] && !m_prev[i]))
                         : in_v[i];
    m_req = nreq;
    m_prev = in_v;
    if (eoi && sf) begin
      m_isr[si] = 1'b0;
      if (m_rot) m_base = (si + 1) % 8;
    end
    if (grant) m_isr[ci] = 1'b1;
    if (we && ad == 2'd0) m_mask = wd;
    if (we && ad == 2'd1) m_rot = wd[0];
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_req = '0; m_prev = '0; m_isr = '0; m_mask = 8'hFF; m_rot = 0; m_base = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step(8'h00, 0, 0, 2'd0, 8'h00, "R1"); check("R1 mask", last_rd, 8'hFF); check("R1 irq", last_irq, 0);
    step(8'h00, 0, 0, 2'd1, 8'h00, "R1"); check("R1 mode", last_rd, 0);
    step(8'h00, 0, 0, 2'd2, 8'h00, "R1"); check("R1 isr", last_rd, 0);

    // R2 masked requests, R6 idle ack
    step(8'h0F, 0, 0, 2'd0, 8'h00, "R2");
    step(8'h0F, 0, 0, 2'd0, 8'h00, "R2"); check("R2 masked irq", last_irq, 0);
    step(8'h0F, 1, 0, 2'd2, 8'h00, "R6"); check("R6 idle vec", last_vec, 7);
    step(8'h0F, 0, 0, 2'd2, 8'h00, "R6"); check("R6 isr unchanged", last_rd, 0);
    step(8'h0F, 0, 1, 2'd0, 8'hF5, "R2");
    step(8'h0F, 0, 0, 2'd0, 8'h00, "R2"); check("R2 mask readback", last_rd, 8'hF5); check("R2 irq", last_irq, 1);

    // R3 fixed order, R5 in-service, R7 lower blocked, R8, R10
    step(8'h0F, 1, 0, 2'd0, 8'h00, "R3"); check("R3 lowest index", last_vec, 1);
    step(8'h0F, 0, 0, 2'd2, 8'h00, "R5"); check("R5 isr bit", last_rd, 8'h02); check("R7 lower blocked", last_irq, 0);
    step(8'h0F, 0, 1, 2'd2, 8'h00, "R8");
    step(8'h08, 0, 0, 2'd2, 8'h00, "R8"); check("R8 retired", last_rd, 0);
    step(8'h08, 1, 0, 2'd0, 8'h00, "R10"); check("R10 level dropped", last_vec, 3);
    step(8'h0A, 0, 0, 2'd0, 8'h00, "R7");
    step(8'h0A, 1, 0, 2'd0, 8'h00, "R7"); check("R7 nesting", last_vec, 1);
    step(8'h00, 0, 0, 2'd2, 8'h00, "R5"); check("R5 nested isr", last_rd, 8'h0A);
    step(8'h00, 0, 1, 2'd2, 8'h00, "R8");
    step(8'h00, 0, 0, 2'd2, 8'h00, "R8"); check("R8 best rank first", last_rd, 8'h08);
    step(8'h00, 0, 1, 2'd2, 8'h00, "R8");
    step(8'h00, 0, 1, 2'd2, 8'h00, "R8");
    step(8'h00, 0, 0, 2'd2, 8'h00, "R8"); check("R8 empty eoi", last_rd, 0);

    // R4 rotating order
    step(8'h00, 0, 1, 2'd0, 8'h00, "R4");
    step(8'h00, 0, 1, 2'd1, 8'h01, "R4");
    step(8'h04, 0, 0, 2'd1, 8'h00, "R11"); check("R11 mode read", last_rd, 1);
    step(8'h04, 1, 0, 2'd0, 8'h00, "R4"); check("R4 first", last_vec, 2);
    step(8'h00, 0, 1, 2'd2, 8'h00, "R4");
    step(8'h22, 0, 0, 2'd0, 8'h00, "R4");
    step(8'h22, 1, 0, 2'd0, 8'h00, "R4"); check("R4 rotated winner", last_vec, 5);
    step(8'h02, 0, 1, 2'd2, 8'h00, "R4");
    step(8'h02, 1, 0, 2'd0, 8'h00, "R4"); check("R4 next", last_vec, 1);
    step(8'h00, 0, 1, 2'd2, 8'h00, "R4");
    step(8'h00, 0, 1, 2'd1, 8'h00, "R4");

    // R9 edge-sensed input 4
    step(8'h10, 0, 0, 2'd0, 8'h00, "R9");
    step(8'h10, 0, 0, 2'd0, 8'h00, "R9"); check("R9 edge raise", last_irq, 1);
    step(8'h10, 1, 0, 2'd0, 8'h00, "R9"); check("R9 edge vec", last_vec, 4);
    step(8'h10, 0, 1, 2'd2, 8'h00, "R9");
    step(8'h10, 0, 0, 2'd0, 8'h00, "R9"); check("R9 held high quiet", last_irq, 0);
    step(8'h10, 1, 0, 2'd0, 8'h00, "R9"); check("R9 no rerequest", last_vec, 7);
    step(8'h00, 0, 0, 2'd0, 8'h00, "R9");
    step(8'h10, 0, 0, 2'd0, 8'h00, "R9");
    step(8'h10, 0, 0, 2'd0, 8'h00, "R9"); check("R9 new edge", last_irq, 1);
    step(8'h10, 1, 0, 2'd0, 8'h00, "R9");
    step(8'h00, 0, 1, 2'd2, 8'h00, "R9");

    // Random traffic against the reference
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] iv, wd;
      bit a, we;
      logic [1:0] ad;
      iv = 8'($urandom) & 8'($urandom);
      a  = ($urandom % 4) == 0;
      we = ($urandom % 5) == 0;
      ad = 2'($urandom);
      wd = (ad == 2'd0) ? (8'($urandom) & 8'($urandom)) : 8'($urandom);
      step(iv, a, we, ad, wd, "RND");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule